// File: doc/BRIEF.md
# JTAG Fast-Data Exchange Sequencer

This block is a host-side engine that drives a four-wire JTAG port (TCK, TMS, TDI, TDO) through one fast-data exchange with a target TAP. The target's instruction register must already hold the fast-data selection, and the TAP must be resting in Run-Test/Idle. On a start strobe the sequencer walks the TAP into Shift-DR. It shifts a leading processor-access handshake bit and then a data word, collects the word the target returns, and brings the TAP back to Run-Test/Idle.

The target signals that it is ready through the handshake bit it shifts out. If that bit is not 1, the whole scan is repeated from the header onward, up to a parameterised number of retries. When the limit is used up, an error flag replaces the done pulse. The TCK frequency is the system clock divided by `2*HALF`. TMS and TDI move when TCK falls, and TDO is captured when TCK rises.

Top module: `fdx_seq`

## Requirements
- R1: After reset, busy, done and error are 0, TCK, TMS and TDI are 0, and the output word and retry count are 0.
- R2: Every attempt begins with TMS = 1, 0, 0 on three successive TCK rising edges, which takes the TAP from Run-Test/Idle to Shift-DR.
- R3: The first bit shifted in Shift-DR is the handshake bit. TDI is 0 for that bit, and the TDO value sampled for it decides whether the attempt succeeds (1) or fails (0).
- R4: After the handshake bit, DW data bits are shifted least significant bit first on TDI and TDO. TMS is 0 for every data bit except the most significant, which carries TMS = 1. Two footer bits with TMS = 1 then 0 follow, so one attempt is exactly DW+6 TCK cycles.
- R5: TCK has a period of 2*HALF system clocks. TMS and TDI change only in the system clock where TCK falls, or at the start strobe while TCK is low. TDO is sampled where TCK rises.
- R6: The output word is loaded with the captured data only at the end of an attempt whose handshake bit was 1. At that point done is high for exactly one system clock.
- R7: A failed attempt repeats the complete sequence, header included, with the same input word, and increments the retry count. The retry count starts at 0 on each accepted start.
- R8: If an attempt fails when the retry count already equals RETRY_MAX, the error flag is set and done does not pulse. The output word keeps its old value. The error flag holds until the next accepted start, which clears it.
- R9: Busy is high from the clock after an accepted start until the clock in which done or error is raised. A start strobe while busy is ignored.
- R10: While busy is low, TCK is held low and does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| din_i | input | DW | Word to send to the target |
| dout_o | output | DW | Last word received from a successful attempt |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-clock pulse on success |
| err_o | output | 1 | Retry limit exhausted, held until next start |
| retry_o | output | $clog2(RETRY_MAX+1) | Failed attempts in the current or last exchange |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to target |
| tdo_i | input | 1 | JTAG data from target |

## Verification
The assertions assume that TDO changes only when TCK falls. They also assume the start strobe is one clock wide, and that the target keeps to the JTAG state sequence so that each attempt ends back in Run-Test/Idle. The bench meets these conditions with a behavioural TAP model clocked by the sequencer's own TCK. The model updates TDO only on falling TCK and captures a 33-bit register in Capture-DR. Its handshake bit is held at 0 for a programmed number of attempts, and that number is swept from zero to one beyond the retry limit. Start pulses are driven on falling system-clock edges and last one clock.

// File: rtl/fdx_pkg.sv
package fdx_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fdx_state_e;

    // Bit positions inside one attempt (k counts TCK cycles):
    // 0..2 header, 3 handshake, 4..dw+3 data, dw+4..dw+5 footer
    localparam int unsigned HS_POS   = 3;
    localparam int unsigned DATA_POS = 4;

    function automatic int unsigned fdx_len(input int unsigned dw);
        return dw + 6;
    endfunction

    function automatic logic fdx_tms_at(input int unsigned k, input int unsigned dw);
        return (k == 0) || (k == dw + 3) || (k == dw + 4);
    endfunction

    function automatic logic fdx_in_shift(input int unsigned k, input int unsigned dw);
        return (k >= HS_POS) && (k <= dw + 3);
    endfunction

    function automatic logic fdx_in_data(input int unsigned k, input int unsigned dw);
        return (k >= DATA_POS) && (k <= dw + 3);
    endfunction

endpackage

// File: rtl/fdx_tckgen.sv
module fdx_tckgen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tck,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          tck_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            tck_q <= ~tck_q;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tck  = tck_q;
    assign rise = en && wrap && !tck_q;
    assign fall = en && wrap &&  tck_q;
endmodule

// File: rtl/fdx_rxshift.sv
module fdx_rxshift #(
    parameter int DW = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        bit_i,
    output logic [DW:0] word_o
);
    // Right shift, newest bit at the top: after DW+1 shifts
    // bit 0 holds the handshake and bits DW:1 the data word.
    always_ff @(posedge clk) begin
        if (rst)
            word_o <= '0;
        else if (en)
            word_o <= {bit_i, word_o[DW:1]};
    end
endmodule

// File: rtl/fdx_ctrl.sv
module fdx_ctrl
    import fdx_pkg::*;
#(
    parameter int DW        = 32,
    parameter int RETRY_MAX = 3,
    localparam int RW       = $clog2(RETRY_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] din,
    input  logic          rise,
    input  logic          fall,
    input  logic [DW:0]   cap,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          tms,
    output logic          tdi,
    output logic          shift_en,
    output logic [DW-1:0] dout,
    output logic [RW-1:0] retry
);
    localparam int LEN = fdx_len(DW);
    localparam int KW  = $clog2(LEN);

    fdx_state_e    st_q;
    logic [KW-1:0] k_q;
    logic [DW-1:0] din_q;
    logic [DW-1:0] tx_q;
    logic [DW-1:0] tx_nxt;
    logic          last_bit;

    assign last_bit = (k_q == KW'(LEN - 1));
    assign tx_nxt   = fdx_in_data(int'(k_q), DW) ? (tx_q >> 1) : tx_q;
    assign busy     = (st_q == ST_RUN);
    assign shift_en = rise && busy && fdx_in_shift(int'(k_q), DW);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            k_q   <= '0;
            din_q <= '0;
            tx_q  <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
            tms   <= 1'b0;
            tdi   <= 1'b0;
            dout  <= '0;
            retry <= '0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q  <= ST_RUN;
                        din_q <= din;
                        tx_q  <= din;
                        k_q   <= '0;
                        tms   <= 1'b1;
                        tdi   <= 1'b0;
                        retry <= '0;
                        err   <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (fall) begin
                        if (last_bit) begin
                            tdi <= 1'b0;
                            if (cap[0]) begin
                                dout <= cap[DW:1];
                                done <= 1'b1;
                                st_q <= ST_IDLE;
                                tms  <= 1'b0;
                            end else if (retry == RW'(RETRY_MAX)) begin
                                err  <= 1'b1;
                                st_q <= ST_IDLE;
                                tms  <= 1'b0;
                            end else begin
                                retry <= retry + RW'(1);
                                k_q   <= '0;
                                tms   <= 1'b1;
                                tx_q  <= din_q;
                            end
                        end else begin
                            k_q  <= k_q + KW'(1);
                            tms  <= fdx_tms_at(int'(k_q) + 1, DW);
                            tdi  <= fdx_in_data(int'(k_q) + 1, DW) ? tx_nxt[0] : 1'b0;
                            tx_q <= tx_nxt;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fdx_seq.sv
module fdx_seq #(
    parameter int DW        = 32,
    parameter int HALF      = 2,
    parameter int RETRY_MAX = 3,
    localparam int RW       = $clog2(RETRY_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] dout_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [RW-1:0] retry_o,
    output logic          tck_o,
    output logic          tms_o,
    output logic          tdi_o,
    input  logic          tdo_i
);
    logic          rise;
    logic          fall;
    logic          shift_en;
    logic [DW:0]   cap;

    fdx_tckgen #(.HALF(HALF)) u_tck (
        .clk  (clk),
        .rst  (rst),
        .en   (busy_o),
        .tck  (tck_o),
        .rise (rise),
        .fall (fall)
    );

    fdx_rxshift #(.DW(DW)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .en     (shift_en),
        .bit_i  (tdo_i),
        .word_o (cap)
    );

    fdx_ctrl #(.DW(DW), .RETRY_MAX(RETRY_MAX)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .din      (din_i),
        .rise     (rise),
        .fall     (fall),
        .cap      (cap),
        .busy     (busy_o),
        .done     (done_o),
        .err      (err_o),
        .tms      (tms_o),
        .tdi      (tdi_o),
        .shift_en (shift_en),
        .dout     (dout_o),
        .retry    (retry_o)
    );
endmodule

// File: rtl/fdx_chk.sv
module fdx_chk #(
    parameter int DW        = 32,
    parameter int RETRY_MAX = 3,
    localparam int RW       = $clog2(RETRY_MAX + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic [DW-1:0] dout_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic [RW-1:0] retry_o,
    input logic          tck_o,
    input logic          tms_o,
    input logic          tdi_o
);
    // R6: done is a single-clock pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: output word moves only together with done
    a_r6_dout_with_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout_o) |-> done_o);

    // R8: retry count never passes the limit
    a_r8_retry_bound: assert property (@(posedge clk) disable iff (rst)
        retry_o <= RW'(RETRY_MAX));

    // R8: error is held until a new start
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_o && !start_i) |=> err_o);

    // R8: error and done never together
    a_r8_err_excl_done: assert property (@(posedge clk) disable iff (rst)
        !(err_o && done_o));

    // R9: busy only drops when done or error is raised
    a_r9_busy_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (done_o || err_o));

    // R10: TCK stays low while idle
    a_r10_idle_tck: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !tck_o);

    // R5: TMS and TDI hold while TCK is high
    a_r5_pins_hold: assert property (@(posedge clk) disable iff (rst)
        (tck_o && $past(tck_o)) |-> ($stable(tms_o) && $stable(tdi_o)));
endmodule

bind fdx_seq fdx_chk #(.DW(DW), .RETRY_MAX(RETRY_MAX)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .dout_o  (dout_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .retry_o (retry_o),
    .tck_o   (tck_o),
    .tms_o   (tms_o),
    .tdi_o   (tdi_o)
);

// File: tb/tb_fdx_seq.sv
`timescale 1ns/1ps
module tb_fdx_seq;
    localparam int DW   = 32;
    localparam int HALF = 2;
    localparam int RMAX = 3;
    localparam int RW   = $clog2(RMAX + 1);
    localparam int LEN  = DW + 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [DW-1:0] din_i = '0;
    logic [DW-1:0] dout_o;
    logic          busy_o, done_o, err_o;
    logic [RW-1:0] retry_o;
    logic          tck_o, tms_o, tdi_o;
    logic          tdo_i = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    fdx_seq #(.DW(DW), .HALF(HALF), .RETRY_MAX(RMAX)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .din_i(din_i),
        .dout_o(dout_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .retry_o(retry_o), .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o),
        .tdo_i(tdo_i));

    // ---------------- target TAP model ----------------
    typedef enum logic [2:0] {T_IDLE, T_SEL, T_CAP, T_SHIFT, T_EX1, T_UPD} tap_e;
    tap_e      tstate = T_IDLE;
    logic [DW:0] tsr = '0;
    logic [DW-1:0] reply = '0;
    int        fail_left = 0;
    int        captures  = 0;
    int        proto_err = 0;
    logic [DW-1:0] rx_word = '0;
    logic      rx_hs = 1'b1;

    always @(posedge tck_o) begin
        case (tstate)
            T_IDLE:  tstate <= tms_o ? T_SEL : T_IDLE;
            T_SEL:   begin
                if (tms_o) proto_err++;
                tstate <= tms_o ? T_IDLE : T_CAP;
            end
            T_CAP:   begin
                tsr <= {reply, (fail_left == 0)};
                if (fail_left > 0) fail_left--;
                captures++;
                tstate <= tms_o ? T_EX1 : T_SHIFT;
            end
            T_SHIFT: begin
                tsr <= {tdi_o, tsr[DW:1]};
                tstate <= tms_o ? T_EX1 : T_SHIFT;
            end
            T_EX1:   begin
                if (!tms_o) proto_err++;
                tstate <= tms_o ? T_UPD : T_IDLE;
            end
            T_UPD:   begin
                if (tms_o) proto_err++;
                tstate <= T_IDLE;
            end
            default: tstate <= T_IDLE;
        endcase
    end

    always @(negedge tck_o) begin
        if (tstate == T_SHIFT) tdo_i <= tsr[0];
        if (tstate == T_UPD) begin
            rx_word <= tsr[DW:1];
            rx_hs   <= tsr[0];
        end
    end

    // ---------------- pin monitors ----------------
    int   rises = 0, dones = 0, period_bad = 0, pin_bad = 0, gap = 0;
    bit   seen_rise = 0;
    logic tck_p = 0, tms_p = 0, tdi_p = 0, busy_p = 0;

    always @(posedge tck_o) rises++;

    always @(negedge clk) begin
        if (!rst) begin
            if (done_o) dones++;
            gap++;
            if (tck_o && !tck_p) begin
                if (seen_rise && gap != 2 * HALF) period_bad++;
                seen_rise = 1;
                gap = 0;
            end
            if ((tms_o !== tms_p || tdi_o !== tdi_p) && !((tck_p && !tck_o) || !busy_p))
                pin_bad++;
        end
        tck_p  = tck_o;
        tms_p  = tms_o;
        tdi_p  = tdi_o;
        busy_p = busy_o;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one exchange: nf = attempts the target refuses, poke = stray start while busy
    task automatic run_xfer(input logic [DW-1:0] d, input int nf, input bit poke);
        logic [DW-1:0] prev;
        logic [DW-1:0] got;
        bit ok;
        int att, n;
        prev = dout_o;
        ok   = (nf <= RMAX);
        att  = ok ? nf + 1 : RMAX + 1;
        @(negedge clk);
        din_i = d; start_i = 1'b1;
        fail_left = nf; reply = ~d ^ 32'h3C5A_96E1;
        rises = 0; dones = 0; period_bad = 0; pin_bad = 0; seen_rise = 0;
        captures = 0; proto_err = 0; rx_hs = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
        chk(err_o == 1'b0, "R8 error cleared by start", err_o, 0);
        if (poke) begin
            repeat (40) @(negedge clk);
            din_i = ~d; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        n = 0;
        while (!(done_o || err_o) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        got = dout_o;
        chk(done_o == ok, "R6/R8 outcome done", done_o, ok);
        chk(err_o == !ok, "R8 error flag", err_o, !ok);
        chk(busy_o == 1'b0, "R9 busy cleared at end", busy_o, 0);
        chk(got == (ok ? reply : prev), "R6 output word", got, ok ? reply : prev);
        chk(retry_o == RW'(ok ? nf : RMAX), "R7 retry count", retry_o, ok ? nf : RMAX);
        @(negedge clk);
        chk(done_o == 1'b0, "R6 done single pulse", done_o, 0);
        chk(dones == (ok ? 1 : 0), "R6 done pulse count", dones, ok ? 1 : 0);
        chk(rises == LEN * att, "R4 TCK cycles per exchange", rises, LEN * att);
        chk(captures == att, "R7 whole sequence repeated", captures, att);
        chk(proto_err == 0 && tstate == T_IDLE, "R2 TAP path header/footer", proto_err, 0);
        chk(rx_word == d, "R4 word received by target LSB first", rx_word, d);
        chk(rx_hs == 1'b0, "R3 handshake driven as 0", rx_hs, 0);
        chk(period_bad == 0, "R5 TCK period", period_bad, 0);
        chk(pin_bad == 0, "R5 TMS/TDI change on falling TCK", pin_bad, 0);
        if (!ok) chk(err_o == 1'b1, "R8 error held while idle", err_o, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1 reset flags", {busy_o, done_o, err_o}, 0);
        chk(tck_o == 0 && tms_o == 0 && tdi_o == 0, "R1 reset pins", {tck_o, tms_o, tdi_o}, 0);
        chk(dout_o == '0 && retry_o == '0, "R1 reset word/retry", dout_o, 0);
        rises = 0;
        repeat (20) @(negedge clk);
        chk(rises == 0, "R10 TCK idle when not busy", rises, 0);

        // sweep refusal counts 0..RMAX+1 over fixed patterns
        for (int nf = 0; nf <= RMAX + 1; nf++) begin
            run_xfer(32'h0000_0012, nf, 0);
            run_xfer(32'hA5C3_0F96, nf, 0);
            run_xfer(32'hFFFF_FFFF, nf, 0);
            run_xfer(32'h8000_0001, nf, 0);
        end
        // walking one across the word, refusals cycling through all counts
        for (int i = 0; i < DW; i++)
            run_xfer(DW'(1) << i, i % (RMAX + 2), 0);

        // R9: stray start while busy ignored
        run_xfer(32'h1357_9BDF, 0, 1);
        run_xfer(32'h2468_ACE0, 2, 1);

        // R8: error then a clean exchange
        run_xfer(32'h0F0F_F0F0, RMAX + 1, 0);
        run_xfer(32'hDEAD_0001, 0, 0);
        rises = 0;
        repeat (20) @(negedge clk);
        chk(rises == 0, "R10 TCK idle after exchange", rises, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule